// File: doc/BRIEF.md
# Supply-Monitor Soft Reset Generator

This block turns the digital undervoltage flag of an external supply comparator into an active-low soft reset. The flag is synchronized and then sampled on a fast sample tick. An undervoltage reading is accepted only after it has held for a run of consecutive samples sized to cover about 15 µs, so brief dips on the supply do not reset the system.

Once a low supply has been accepted, the soft reset is held for the whole undervoltage interval. After the supply recovers, the reset is stretched by a coded number of millisecond ticks. A soft-reset request from the push-button hold-down timer is stretched by the same duration code. The two requests are ORed into the single output.

The block also registers a 3-bit threshold code and drives it to the comparator reference. The comparator and the reference themselves lie outside the block.

Top module: `soft_reset_supervisor`

## Requirements
- R1: During reset and after it, `soft_rst_n_o` is low (asserted), and it stays low until the first sample tick has been taken. A value of 0 means reset asserted and 1 means released. `thresh_sel_o` resets to 3'b010.
- R2: When `uv_flag_i` is high for fewer than FILT_LEN consecutive sample ticks and the next sample is low, `soft_rst_n_o` stays high.
- R3: When `uv_flag_i` is high on FILT_LEN consecutive sample ticks, `soft_rst_n_o` goes low. It stays low while further high samples arrive, whatever the number of ms ticks meanwhile.
- R4: A single low sample clears the run of high samples, so FILT_LEN-1 high, 1 low and FILT_LEN-1 high samples do not assert the reset.
- R5: After the first low sample that follows an accepted undervoltage, `soft_rst_n_o` stays low for exactly D ms ticks and goes high after the D-th. D is set by `dur_code_i`: 2'b00=1, 2'b01=25, 2'b10=100, 2'b11=200.
- R6: If undervoltage is accepted again while the post-recovery stretch is counting, the count is discarded. A full D ms ticks is counted again after the next recovery.
- R7: A high cycle on `man_req_i` asserts `soft_rst_n_o` within two clock cycles. The reset is released after D ms ticks, with D from the same code as R5.
- R8: `soft_rst_n_o` is the OR of both requests. It is released only when neither the undervoltage stretch nor the manual stretch is still active.
- R9: `thresh_sel_o` equals `thresh_code_i` one clock later. The codes 3'b000 to 3'b111 select 4.50, 4.25, 2.97, 2.81, 2.70, 2.55, 2.43 and 2.30 V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick_i | input | 1 | One-cycle strobe that samples the undervoltage flag |
| ms_tick_i | input | 1 | One-cycle strobe once per millisecond |
| uv_flag_i | input | 1 | Comparator output, high when the supply is below threshold (asynchronous) |
| thresh_code_i | input | 3 | Threshold select code |
| dur_code_i | input | 2 | Reset stretch duration code |
| man_req_i | input | 1 | Soft-reset request from the push-button timer |
| thresh_sel_o | output | 3 | Registered threshold code to the comparator reference |
| soft_rst_n_o | output | 1 | Active-low soft reset |

## Verification
The bench builds the block with FILT_LEN set to 5 and keeps the default synchronizer depth and the default duration table. The short filter lets the bench step through the run of samples one at a time: the run that falls one short, the run broken by a single good sample, and the run that reaches acceptance. Because the bench drives the millisecond tick every other clock, it can count each full duration, including 200, tick by tick. It can also test restart and the overlap of the two requests with exact tick counts.

// File: rtl/srs_pkg.sv
package srs_pkg;
   typedef logic [1:0] dur_code_t;
   typedef logic [2:0] thr_code_t;

   localparam int NUM_SRC = 2;
   localparam int SRC_UV  = 0;
   localparam int SRC_MAN = 1;

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction
endpackage

// File: rtl/srs_glitch_filter.sv
module srs_glitch_filter #(
   parameter int FILT_LEN    = 15,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sample_tick,
   input  logic uv_async,
   output logic uv_acc,
   output logic valid
);
   localparam int CW = $clog2(FILT_LEN + 1);
   localparam logic [CW-1:0] FULL = CW'(FILT_LEN);

   logic          uv_s;
   logic [CW-1:0] run_q;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign uv_s = uv_async;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else if (SYNC_STAGES == 1) chain_q <= uv_async;
            else chain_q <= {chain_q[SYNC_STAGES-2:0], uv_async};
         end
         assign uv_s = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
         valid <= 1'b0;
      end else if (sample_tick) begin
         valid <= 1'b1;
         if (!uv_s)             run_q <= '0;
         else if (run_q != FULL) run_q <= run_q + 1'b1;
      end
   end

   assign uv_acc = (run_q == FULL);
endmodule

// File: rtl/srs_stretch.sv
module srs_stretch
   import srs_pkg::*;
#(
   parameter int DUR0 = 1,
   parameter int DUR1 = 25,
   parameter int DUR2 = 100,
   parameter int DUR3 = 200
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      hold,
   input  logic      ms_tick,
   input  dur_code_t dur_code,
   output logic      active
);
   localparam int MAXD = max4(DUR0, DUR1, DUR2, DUR3);
   localparam int CW   = $clog2(MAXD + 1);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] target;
   logic [CW-1:0] cnt_nxt;

   always_comb begin
      case (dur_code)
         2'b00:   target = CW'(DUR0);
         2'b01:   target = CW'(DUR1);
         2'b10:   target = CW'(DUR2);
         default: target = CW'(DUR3);
      endcase
   end

   assign cnt_nxt = cnt_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt_q  <= '0;
      end else if (hold) begin
         active <= 1'b1;
         cnt_q  <= '0;
      end else if (active && ms_tick) begin
         if (cnt_nxt >= target) begin
            active <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q  <= cnt_nxt;
         end
      end
   end
endmodule

// File: rtl/soft_reset_supervisor.sv
module soft_reset_supervisor
   import srs_pkg::*;
#(
   parameter int        FILT_LEN    = 15,
   parameter int        SYNC_STAGES = 2,
   parameter int        DUR0        = 1,
   parameter int        DUR1        = 25,
   parameter int        DUR2        = 100,
   parameter int        DUR3        = 200,
   parameter logic [2:0] THR_RESET  = 3'b010
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sample_tick_i,
   input  logic       ms_tick_i,
   input  logic       uv_flag_i,
   input  logic [2:0] thresh_code_i,
   input  logic [1:0] dur_code_i,
   input  logic       man_req_i,
   output logic [2:0] thresh_sel_o,
   output logic       soft_rst_n_o
);
   generate
      if (FILT_LEN < 1) begin : g_bad_filt
         $error("FILT_LEN must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 to 4");
      end
      if (DUR0 < 1 || DUR1 < 1 || DUR2 < 1 || DUR3 < 1) begin : g_bad_dur
         $error("every duration must be at least 1 ms");
      end
   endgenerate

   logic               uv_acc;
   logic               valid;
   logic [NUM_SRC-1:0] hold;
   logic [NUM_SRC-1:0] act;
   thr_code_t          thr_q;
   logic               rst_q;

   srs_glitch_filter #(
      .FILT_LEN   (FILT_LEN),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_filt (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_tick(sample_tick_i),
      .uv_async   (uv_flag_i),
      .uv_acc     (uv_acc),
      .valid      (valid)
   );

   assign hold[SRC_UV]  = uv_acc;
   assign hold[SRC_MAN] = man_req_i;

   generate
      for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
         srs_stretch #(
            .DUR0(DUR0), .DUR1(DUR1), .DUR2(DUR2), .DUR3(DUR3)
         ) u_str (
            .clk     (clk),
            .rst_n   (rst_n),
            .hold    (hold[g]),
            .ms_tick (ms_tick_i),
            .dur_code(dur_code_i),
            .active  (act[g])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_q <= 1'b0;
         thr_q <= THR_RESET;
      end else begin
         rst_q <= valid && (act == '0);
         thr_q <= thresh_code_i;
      end
   end

   assign soft_rst_n_o = rst_q;
   assign thresh_sel_o = thr_q;
endmodule

// File: rtl/srs_checker.sv
module srs_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       sample_tick_i,
   input logic       man_req_i,
   input logic [2:0] thresh_code_i,
   input logic [2:0] thresh_sel_o,
   input logic       soft_rst_n_o,
   input logic       uv_acc
);
   logic seen_sample;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_sample <= 1'b0;
      else if (sample_tick_i) seen_sample <= 1'b1;
   end

   AST_LOW_BEFORE_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_sample |-> !soft_rst_n_o); // R1
   AST_ACCEPT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(uv_acc) |-> $past(sample_tick_i)); // R2
   AST_UV_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
      uv_acc |=> ##1 !soft_rst_n_o); // R3
   AST_MAN_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
      man_req_i |=> ##1 !soft_rst_n_o); // R7
   AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(soft_rst_n_o) |-> (!$past(uv_acc, 2) && !$past(man_req_i, 2))); // R8
   AST_THR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (thresh_sel_o == $past(thresh_code_i))); // R9
endmodule

bind soft_reset_supervisor srs_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sample_tick_i(sample_tick_i),
   .man_req_i    (man_req_i),
   .thresh_code_i(thresh_code_i),
   .thresh_sel_o (thresh_sel_o),
   .soft_rst_n_o (soft_rst_n_o),
   .uv_acc       (uv_acc)
);

// File: tb/soft_reset_supervisor_tb.sv
`timescale 1ns/1ps
module soft_reset_supervisor_tb;
   localparam int FL = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sample_tick = 1'b0;
   logic       ms_tick = 1'b0;
   logic       uv = 1'b0;
   logic [2:0] thr = 3'b000;
   logic [1:0] dur = 2'b00;
   logic       man = 1'b0;
   logic [2:0] thr_o;
   logic       srst_n;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   soft_reset_supervisor #(.FILT_LEN(FL)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .sample_tick_i(sample_tick),
      .ms_tick_i    (ms_tick),
      .uv_flag_i    (uv),
      .thresh_code_i(thr),
      .dur_code_i   (dur),
      .man_req_i    (man),
      .thresh_sel_o (thr_o),
      .soft_rst_n_o (srst_n)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic sample(input logic v);
      uv = v;
      repeat (3) @(negedge clk);
      sample_tick = 1'b1;
      @(negedge clk);
      sample_tick = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic ms(input int n);
      for (int i = 0; i < n; i++) begin
         ms_tick = 1'b1;
         @(negedge clk);
         ms_tick = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic pulse_man();
      man = 1'b1;
      @(negedge clk);
      man = 1'b0;
      @(negedge clk);
   endtask

   task automatic accept_uv();
      for (int i = 0; i < FL; i++) sample(1'b1);
   endtask

   function automatic int dur_of(input logic [1:0] c);
      case (c)
         2'b00: return 1;
         2'b01: return 25;
         2'b10: return 100;
         default: return 200;
      endcase
   endfunction

   task automatic t_reset();
      check("R1 low in reset", srst_n, 0);
      check("R1 thresh reset", thr_o, 3'b010);
      @(negedge clk); rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R1 low before first sample", srst_n, 0);
      ms(3);
      check("R1 low before first sample after ms", srst_n, 0);
      sample(1'b0);
      check("R1 released after first good sample", srst_n, 1);
   endtask

   task automatic t_glitch();
      for (int i = 0; i < FL - 1; i++) begin
         sample(1'b1);
         check("R2 short run stays high", srst_n, 1);
      end
      sample(1'b0);
      ms(2);
      check("R2 after glitch", srst_n, 1);
   endtask

   task automatic t_run_clear();
      for (int i = 0; i < FL - 1; i++) sample(1'b1);
      sample(1'b0);
      for (int i = 0; i < FL - 1; i++) sample(1'b1);
      check("R4 broken run no reset", srst_n, 1);
      sample(1'b0);
      check("R4 after broken run", srst_n, 1);
   endtask

   task automatic t_accept();
      dur = 2'b00;
      for (int i = 0; i < FL - 1; i++) sample(1'b1);
      check("R3 one short", srst_n, 1);
      sample(1'b1);
      check("R3 accepted", srst_n, 0);
      ms(3);
      sample(1'b1);
      ms(3);
      check("R3 held while low", srst_n, 0);
      sample(1'b0);
      check("R5 code00 still low at release", srst_n, 0);
      ms(1);
      check("R5 code00 released after 1", srst_n, 1);
   endtask

   task automatic t_durations();
      for (int c = 1; c < 4; c++) begin
         dur = 2'(c);
         accept_uv();
         sample(1'b0);
         ms(dur_of(dur) - 1);
         check("R5 low at D-1", srst_n, 0);
         ms(1);
         check("R5 high at D", srst_n, 1);
      end
   endtask

   task automatic t_restart();
      dur = 2'b01;
      accept_uv();
      sample(1'b0);
      ms(20);
      accept_uv();
      check("R6 reaccepted", srst_n, 0);
      sample(1'b0);
      ms(24);
      check("R6 restarted count low at 24", srst_n, 0);
      ms(1);
      check("R6 released at 25", srst_n, 1);
   endtask

   task automatic t_manual();
      dur = 2'b01;
      pulse_man();
      check("R7 manual asserts", srst_n, 0);
      ms(24);
      check("R7 manual low at 24", srst_n, 0);
      ms(1);
      check("R7 manual released at 25", srst_n, 1);
   endtask

   task automatic t_merge();
      dur = 2'b01;
      pulse_man();
      ms(10);
      accept_uv();
      ms(20);
      check("R8 held by uv after manual expired", srst_n, 0);
      sample(1'b0);
      ms(24);
      check("R8 uv stretch low at 24", srst_n, 0);
      ms(1);
      check("R8 released when both idle", srst_n, 1);
      accept_uv();
      sample(1'b0);
      ms(20);
      pulse_man();
      ms(24);
      check("R8 manual extends past uv stretch", srst_n, 0);
      ms(1);
      check("R8 released after manual stretch", srst_n, 1);
   endtask

   task automatic t_thresh();
      logic [2:0] codes [3] = '{3'b000, 3'b111, 3'b101};
      foreach (codes[i]) begin
         thr = codes[i];
         repeat (2) @(negedge clk);
         check("R9 thresh follows", thr_o, codes[i]);
      end
      check("R9 thresh no effect on reset", srst_n, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_glitch();
      t_run_clear();
      t_accept();
      t_durations();
      t_restart();
      t_manual();
      t_merge();
      t_thresh();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule